// File: doc/BRIEF.md
# Address Protection and Relocation Unit

This block sits between an address source and the system bus and screens every memory request. A request made in supervisor mode goes to the bus untouched. A request made in user mode is judged by one of three checking schemes, selected by a mode register:

- **Lower guard:** a single guard register keeps user code out of the protected low region.
- **Window:** a pair of registers brackets the region the current task may use.
- **Offset:** a limit register caps the logical address, and a base register then shifts it into place in physical memory.

Legal requests leave the block one cycle later as a bus address with a valid pulse. Illegal ones raise a trap flag instead.

Privileged software loads the guard, window, limit and base registers through a small write port, typically at each task switch. Writes made without the supervisor flag are dropped.

Top module: `access_guard`

## Requirements
- R1: After reset `busValid` and `trapFlag` are 0, `busAddr` is 0, the mode is lower-guard and the guard value is 0, so any user access is forwarded unchanged.
- R2: In lower-guard mode (mode code 0) a user address strictly below the guard register traps; an address equal to or above it is forwarded unchanged.
- R3: In window mode (mode code 1) a user address below the low register or above the high register traps; addresses from low to high inclusive are forwarded unchanged.
- R4: In offset mode (mode code 2) a user address greater than the limit register traps; an address equal to the limit is legal.
- R5: In offset mode a legal user address is forwarded as base plus address.
- R6: In offset mode, if base plus address carries out of the address width, the access traps instead of wrapping.
- R7: A request with `reqSuper` high is always forwarded unchanged with no trap, whatever the mode.
- R8: Results appear exactly one cycle after the request. `busValid` pulses for one cycle per legal request and is 0 in any cycle that follows no request.
- R9: A trap never coincides with `busValid`. `trapFlag` holds its value until the next request, and `busAddr` keeps its last forwarded value across traps and idle cycles.
- R10: Register writes use `cfgSel` codes 0 for mode, 1 for guard, 2 for low, 3 for high, 4 for base and 5 for limit. A write with `reqSuper` low is ignored.
- R11: A register write is in force for any request issued in a later cycle.
- R12: Mode code 3 is a lockout: every user access traps, while supervisor accesses still pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe |
| reqAddr | input | AW | Requested address |
| reqSuper | input | 1 | High for supervisor-mode request or write |
| cfgWrite | input | 1 | Register write strobe |
| cfgSel | input | 3 | Register selector |
| cfgData | input | AW | Register write data |
| busAddr | output | AW | Physical address for the bus |
| busValid | output | 1 | One-cycle pulse when busAddr is a forwarded request |
| trapFlag | output | 1 | Illegal-address trap, held until next request |

## Verification
Each mode is driven with addresses placed one below, exactly on and one above every bound it uses. This separates strict from inclusive comparisons and exposes off-by-one errors on each register. In offset mode, a high base with offsets either side of the carry point tells a wrapping adder apart from one that traps. Supervisor requests, user-mode writes and idle cycles after a trap show that the bypass, the write gating and the trap hold each act on their own.

// File: rtl/access_guard_pkg.sv
package access_guard_pkg;

  typedef enum logic [1:0] {
    MODE_GUARD  = 2'd0,
    MODE_WINDOW = 2'd1,
    MODE_OFFSET = 2'd2,
    MODE_LOCK   = 2'd3
  } guardMode_t;

  typedef enum logic [2:0] {
    SEL_MODE  = 3'd0,
    SEL_GUARD = 3'd1,
    SEL_LOW   = 3'd2,
    SEL_HIGH  = 3'd3,
    SEL_BASE  = 3'd4,
    SEL_LIMIT = 3'd5
  } cfgSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cfgEn;
    logic capture;
    logic grant;
    logic trap;
    logic useSum;
  } guardCtl_t;

  // comparison results from datapath to control
  typedef struct packed {
    logic belowGuard;
    logic belowLow;
    logic aboveHigh;
    logic overLimit;
    logic sumCarry;
  } guardFlags_t;

endpackage

// File: rtl/access_guard_ctrl.sv
module access_guard_ctrl
  import access_guard_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic        reqSuper,
  input  logic        cfgWrite,
  input  logic [2:0]  cfgSel,
  input  logic [1:0]  cfgModeData,
  input  guardFlags_t flags,
  output guardCtl_t   ctl
);

  guardMode_t modeQ;
  logic       userTrap;

  // mode register, writable only from supervisor
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeQ <= MODE_GUARD;
    end else if (ctl.cfgEn && cfgSel == SEL_MODE) begin
      modeQ <= guardMode_t'(cfgModeData);
    end
  end

  always_comb begin
    unique case (modeQ)
      MODE_GUARD:  userTrap = flags.belowGuard;
      MODE_WINDOW: userTrap = flags.belowLow | flags.aboveHigh;
      MODE_OFFSET: userTrap = flags.overLimit | flags.sumCarry;
      default:     userTrap = 1'b1;
    endcase
  end

  always_comb begin
    ctl         = '0;
    ctl.cfgEn   = cfgWrite && reqSuper;
    ctl.capture = reqValid;
    ctl.useSum  = !reqSuper && modeQ == MODE_OFFSET;
    if (reqValid) begin
      ctl.trap  = !reqSuper && userTrap;
      ctl.grant = !ctl.trap;
    end
  end

  // a user-mode write must leave the mode untouched
  assert_ignore_user_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWrite && !reqSuper) |=> $stable(modeQ));

  // the supervisor path never traps
  assert_super_no_trap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqSuper) |-> !ctl.trap);

endmodule

// File: rtl/access_guard_dpath.sv
module access_guard_dpath
  import access_guard_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  guardCtl_t     ctl,
  input  logic [AW-1:0] reqAddr,
  input  logic [2:0]    cfgSel,
  input  logic [AW-1:0] cfgData,
  output guardFlags_t   flags,
  output logic [AW-1:0] busAddr,
  output logic          busValid,
  output logic          trapFlag
);

  localparam logic [AW-1:0] ALL_ONES = {AW{1'b1}};

  logic [AW-1:0] guardQ, lowQ, highQ, baseQ, limitQ;
  logic [AW:0]   sumWide;
  logic [AW-1:0] busAddrQ;
  logic          busValidQ, trapQ;

  // protection registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      guardQ <= '0;
      lowQ   <= '0;
      highQ  <= ALL_ONES;
      baseQ  <= '0;
      limitQ <= ALL_ONES;
    end else if (ctl.cfgEn) begin
      case (cfgSel)
        SEL_GUARD: guardQ <= cfgData;
        SEL_LOW:   lowQ   <= cfgData;
        SEL_HIGH:  highQ  <= cfgData;
        SEL_BASE:  baseQ  <= cfgData;
        SEL_LIMIT: limitQ <= cfgData;
        default:   ;
      endcase
    end
  end

  // comparators and relocation adder
  always_comb begin
    sumWide          = {1'b0, baseQ} + {1'b0, reqAddr};
    flags.belowGuard = reqAddr < guardQ;
    flags.belowLow   = reqAddr < lowQ;
    flags.aboveHigh  = reqAddr > highQ;
    flags.overLimit  = reqAddr > limitQ;
    flags.sumCarry   = sumWide[AW];
  end

  // registered outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busAddrQ  <= '0;
      busValidQ <= 1'b0;
      trapQ     <= 1'b0;
    end else begin
      busValidQ <= ctl.grant;
      if (ctl.capture) trapQ <= ctl.trap;
      if (ctl.grant)   busAddrQ <= ctl.useSum ? sumWide[AW-1:0] : reqAddr;
    end
  end

  assign busAddr  = busAddrQ;
  assign busValid = busValidQ;
  assign trapFlag = trapQ;

  assert_trap_excludes_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busValidQ && trapQ));

  assert_trap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.capture |=> $stable(trapQ));

  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.grant |=> $stable(busAddrQ));

  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.useSum && flags.sumCarry) |-> !ctl.grant);

endmodule

// File: rtl/access_guard.sv
module access_guard
  import access_guard_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reqValid,
  input  logic [AW-1:0] reqAddr,
  input  logic          reqSuper,
  input  logic          cfgWrite,
  input  logic [2:0]    cfgSel,
  input  logic [AW-1:0] cfgData,
  output logic [AW-1:0] busAddr,
  output logic          busValid,
  output logic          trapFlag
);

  guardCtl_t   ctl;
  guardFlags_t flags;

  access_guard_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .reqValid    (reqValid),
    .reqSuper    (reqSuper),
    .cfgWrite    (cfgWrite),
    .cfgSel      (cfgSel),
    .cfgModeData (cfgData[1:0]),
    .flags       (flags),
    .ctl         (ctl)
  );

  access_guard_dpath #(.AW(AW)) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl),
    .reqAddr  (reqAddr),
    .cfgSel   (cfgSel),
    .cfgData  (cfgData),
    .flags    (flags),
    .busAddr  (busAddr),
    .busValid (busValid),
    .trapFlag (trapFlag)
  );

  assert_one_cycle_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> (busValid || trapFlag));

  assert_idle_no_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !busValid);

  assert_super_passthrough_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqSuper) |=> (busValid && !trapFlag && busAddr == $past(reqAddr)));

endmodule

// File: tb/access_guard_bench.sv
module access_guard_bench;

  localparam int AW = 16;
  localparam time CLK_PERIOD = 4ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic          reqSuper = 1'b0;
  logic          cfgWrite = 1'b0;
  logic [2:0]    cfgSel = '0;
  logic [AW-1:0] cfgData = '0;
  logic [AW-1:0] busAddr;
  logic          busValid;
  logic          trapFlag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  access_guard #(.AW(AW)) u_access_guard (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSuper(reqSuper), .cfgWrite(cfgWrite), .cfgSel(cfgSel), .cfgData(cfgData),
    .busAddr(busAddr), .busValid(busValid), .trapFlag(trapFlag)
  );

  task automatic check(input string tag, input logic expV, input logic expT,
                       input logic [AW-1:0] expA);
    checks++;
    if (busValid !== expV || trapFlag !== expT || busAddr !== expA) begin
      fails++;
      $display("FAIL %s: got valid=%0b trap=%0b addr=%h, expected valid=%0b trap=%0b addr=%h",
               tag, busValid, trapFlag, busAddr, expV, expT, expA);
    end
  endtask

  // write one register, then return to idle
  task automatic cfgWr(input logic [2:0] sel, input logic [AW-1:0] data, input logic sup);
    @(negedge clk);
    cfgWrite = 1'b1; cfgSel = sel; cfgData = data; reqSuper = sup;
    @(negedge clk);
    cfgWrite = 1'b0; reqSuper = 1'b0;
  endtask

  // one request; outputs sampled on the next falling edge
  task automatic access(input logic [AW-1:0] addr, input logic sup);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = addr; reqSuper = sup;
    @(negedge clk);
    reqValid = 1'b0; reqSuper = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic testReset();
    check("R1 reset state", 1'b0, 1'b0, 16'h0000);
    access(16'h0123, 1'b0);
    check("R1 default guard passes", 1'b1, 1'b0, 16'h0123);
  endtask

  task automatic testGuard();
    cfgWr(3'd0, 16'h0000, 1'b1);
    cfgWr(3'd1, 16'h1000, 1'b1);
    access(16'h1000, 1'b0);
    check("R2 on guard passes", 1'b1, 1'b0, 16'h1000);
    idle();
    check("R8 valid is one pulse", 1'b0, 1'b0, 16'h1000);
    access(16'h0FFF, 1'b0);
    check("R2 below guard traps", 1'b0, 1'b1, 16'h1000);
    idle();
    check("R9 trap held while idle", 1'b0, 1'b1, 16'h1000);
    access(16'h0010, 1'b1);
    check("R7 supervisor bypass", 1'b1, 1'b0, 16'h0010);
  endtask

  task automatic testWindow();
    cfgWr(3'd0, 16'h0001, 1'b1);
    cfgWr(3'd2, 16'h2000, 1'b1);
    cfgWr(3'd3, 16'h2FFF, 1'b1);
    access(16'h1FFF, 1'b0);
    check("R3 below low traps", 1'b0, 1'b1, 16'h0010);
    access(16'h2000, 1'b0);
    check("R3 low edge passes", 1'b1, 1'b0, 16'h2000);
    access(16'h2FFF, 1'b0);
    check("R3 high edge passes", 1'b1, 1'b0, 16'h2FFF);
    access(16'h3000, 1'b0);
    check("R3 above high traps", 1'b0, 1'b1, 16'h2FFF);
  endtask

  task automatic testOffset();
    cfgWr(3'd0, 16'h0002, 1'b1);
    cfgWr(3'd4, 16'h4000, 1'b1);
    cfgWr(3'd5, 16'h0100, 1'b1);
    access(16'h0100, 1'b0);
    check("R4 R5 limit edge relocated", 1'b1, 1'b0, 16'h4100);
    access(16'h0101, 1'b0);
    check("R4 over limit traps", 1'b0, 1'b1, 16'h4100);
    access(16'h0000, 1'b0);
    check("R5 zero offset relocated", 1'b1, 1'b0, 16'h4000);
    access(16'h0030, 1'b1);
    check("R7 supervisor not relocated", 1'b1, 1'b0, 16'h0030);
  endtask

  task automatic testCarry();
    cfgWr(3'd4, 16'hFF00, 1'b1);
    cfgWr(3'd5, 16'hFFFF, 1'b1);
    access(16'h00FF, 1'b0);
    check("R6 top address reached", 1'b1, 1'b0, 16'hFFFF);
    access(16'h0100, 1'b0);
    check("R6 carry traps", 1'b0, 1'b1, 16'hFFFF);
  endtask

  task automatic testWriteRules();
    // user-mode write of limit 0 must be dropped
    cfgWr(3'd5, 16'h0000, 1'b0);
    access(16'h0050, 1'b0);
    check("R10 user write ignored", 1'b1, 1'b0, 16'hFF50);
    // supervisor write followed immediately by a user request
    cfgWr(3'd4, 16'h0100, 1'b1);
    access(16'h0050, 1'b0);
    check("R11 new base in force", 1'b1, 1'b0, 16'h0150);
  endtask

  task automatic testLock();
    cfgWr(3'd0, 16'h0003, 1'b1);
    access(16'h5000, 1'b0);
    check("R12 lockout traps user", 1'b0, 1'b1, 16'h0150);
    access(16'h5000, 1'b1);
    check("R12 lockout passes supervisor", 1'b1, 1'b0, 16'h5000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    testReset();
    testGuard();
    testWindow();
    testOffset();
    testCarry();
    testWriteRules();
    testLock();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule